// File: doc/BRIEF.md
# Tunable Pseudo-Random Press Generator

This block stands in for a human player's button in a reaction game. It runs a nine-stage shift register with XNOR feedback that steps through a fixed, random-looking order of values. Each cycle it compares the register's current value with a nine-bit level taken from a bank of switches, and it raises a press whenever the register value is below that level. Because the register visits every value from 0 to 510 exactly once per period, the level sets the press rate directly: a level of N gives N presses in every 511 cycles.

The block is meant to run on a slow clock taken from a divider tap (bit 15 of a divided system clock, roughly 768 Hz), so that a human opponent can keep up. The divider and the game itself sit outside this block. The register state is brought out so that the sequence can be checked.

Top module: `cyber_press_gen`

## Requirements
- R1: On each rising clock edge with reset inactive, state bit k takes the previous value of bit k-1, for k from 1 to 8 (bit 0 is the first stage, bit 8 the ninth).
- R2: The new bit 0 equals the XNOR of the previous bit 8 and bit 4 (the ninth and fifth stages).
- R3: The state 9'h1FF (all ones) never appears after reset.
- R4: A rising edge with rst_n low loads state 0, both at start-up and in the middle of a run.
- R5: Starting from state 0, the state first returns to 0 after exactly 511 clock edges.
- R6: press_o is 1 exactly when lfsr_state_o is less than sw_level as unsigned numbers, in the same cycle, with no register in between.
- R7: With sw_level equal to 0, press_o stays 0; with sw_level equal to 511, press_o stays 1.
- R8: Over one full period of 511 consecutive states, the number of cycles with press_o high equals sw_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow game clock from a divider tap |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_level | input | 9 | Press-rate setting from the switches |
| press_o | output | 1 | Pseudo-random press request |
| lfsr_state_o | output | 9 | Current shift register value |

## Verification
The bench follows the register with its own model of the shift and the XNOR of stages nine and five, so a tap taken from the wrong stage or a plain XOR in place of XNOR shows up as a state mismatch within a few cycles, and an XOR register would also stick at zero after reset. It runs whole periods at levels 0, 511 and several random values and counts presses; a comparator that used less-or-equal would give one press too many per period and press at level 0, and a short sequence would return to zero early. It also pulls reset in the middle of a run to catch a reset that only works at start-up.

// File: rtl/cyber_pkg.sv
// Shared constants and types for the pseudo-random press generator.
// Assumes stage numbering from 1, with stage 1 held in bit 0.
package cyber_pkg;
    parameter int LFSR_W  = 9;  // number of shift stages
    parameter int TAP_HI  = 9;  // first feedback stage (1-based)
    parameter int TAP_LO  = 5;  // second feedback stage (1-based)
    localparam int PERIOD = (1 << LFSR_W) - 1;
    typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/xnor_lfsr.sv
// Shift register with XNOR feedback from two stages.
// Assumes the taps give a maximal-length sequence; the all-ones value is
// the lockup state, and reset loads zero, which lies on the sequence.
module xnor_lfsr #(
    parameter int WIDTH  = 9,
    parameter int TAP_HI = 9,
    parameter int TAP_LO = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state_o
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             feedback;

    // Feedback into the first stage.
    assign feedback = ~(state_q[TAP_HI-1] ^ state_q[TAP_LO-1]);
    assign state_d[0] = feedback;

    // Each later stage takes the value of the one before it.
    generate
        for (genvar g = 1; g < WIDTH; g++) begin : g_stage
            assign state_d[g] = state_q[g-1];
        end
    endgenerate

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R1: stages move up by one per clock.
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));

    // R2: first stage gets XNOR of the two tap stages.
    p_feedback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q[0] == ($past(state_q[TAP_HI-1]) ~^ $past(state_q[TAP_LO-1])));

    // R3: lockup value never reached.
    p_no_lockup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q != '1);

    // R4: reset loads zero.
    p_reset_zero_r4: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);
endmodule

// File: rtl/rate_compare.sv
// Unsigned magnitude compare that turns the register value into a press.
// Assumes both operands share one width; purely combinational.
module rate_compare #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic [WIDTH-1:0] level_i,
    output logic             press_o
);
    // Press when the random value lies below the level.
    always_comb begin
        press_o = (value_i < level_i);
    end
endmodule

// File: rtl/cyber_press_gen.sv
// Top of the press generator: an XNOR shift register whose value is compared
// with a switch level each cycle. Assumes a slow clock from a divider tap.
module cyber_press_gen
    import cyber_pkg::*;
#(
    parameter int W     = LFSR_W,
    parameter int T_HI  = TAP_HI,
    parameter int T_LO  = TAP_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sw_level,
    output logic         press_o,
    output logic [W-1:0] lfsr_state_o
);
    logic [W-1:0] state_w;

    // Sequence source.
    xnor_lfsr #(.WIDTH(W), .TAP_HI(T_HI), .TAP_LO(T_LO)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (state_w)
    );

    // Rate setting compare.
    rate_compare #(.WIDTH(W)) u_cmp (
        .value_i (state_w),
        .level_i (sw_level),
        .press_o (press_o)
    );

    assign lfsr_state_o = state_w;

    // R7: zero level never presses.
    p_zero_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_level == '0) |-> !press_o);

    // R7: full level always presses, since all ones never occurs.
    p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_level == '1) |-> press_o);
endmodule

// File: tb/tb_cyber_press_gen.sv
module tb_cyber_press_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] sw_level;
    logic       press_o;
    logic [8:0] lfsr_state_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [8:0] model;

    cyber_press_gen dut (
        .clk(clk), .rst_n(rst_n), .sw_level(sw_level),
        .press_o(press_o), .lfsr_state_o(lfsr_state_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic [8:0] next_state(input logic [8:0] s);
        logic fb;
        fb = ~(s[8] ^ s[4]);
        return {s[7:0], fb};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: apply level, advance model, compare state and press.
    task automatic step(input logic [8:0] lvl);
        sw_level = lvl;
        @(posedge clk);
        #1;
        model = rst_n ? next_state(model) : 9'd0;
        check(lfsr_state_o == model, "R1/R2 state", lfsr_state_o, model);
        check(lfsr_state_o != 9'h1FF, "R3 lockup", lfsr_state_o, 0);
        check(press_o == (model < lvl), "R6 press", press_o, model < lvl);
    endtask

    // A full period from state 0 at a fixed level.
    task automatic run_period(input logic [8:0] lvl);
        int cnt = 0;
        int early = 0;
        sw_level = lvl;
        #1;
        for (int k = 0; k < 511; k++) begin
            if (press_o) cnt++;
            if (k > 0 && lfsr_state_o == 9'd0) early++;
            if (lvl == 9'd0) check(!press_o, "R7 zero level", press_o, 0);
            if (lvl == 9'h1FF) check(press_o, "R7 full level", press_o, 1);
            step(lvl);
        end
        check(early == 0, "R5 early return", early, 0);
        check(lfsr_state_o == 9'd0, "R5 period 511", lfsr_state_o, 0);
        check(cnt == int'(lvl), "R8 press count", cnt, lvl);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        sw_level = 9'd0;
        model = 9'd0;
        repeat (2) @(posedge clk);
        #1;
        check(lfsr_state_o == 9'd0, "R4 reset state", lfsr_state_o, 0);
        check(press_o == 1'b0, "R7 reset press", press_o, 0);
        rst_n = 1'b1;

        run_period(9'd0);
        run_period(9'h1FF);
        run_period(9'd1);
        run_period(9'd510);
        for (int r = 0; r < 4; r++) run_period(9'($urandom_range(0, 511)));

        // Random level every cycle.
        for (int i = 0; i < 700; i++) step(9'($urandom));

        // Mid-run reset, R4.
        rst_n = 1'b0;
        step(9'd300);
        check(lfsr_state_o == 9'd0, "R4 mid-run reset", lfsr_state_o, 0);
        rst_n = 1'b1;
        step(9'd300);
        check(lfsr_state_o == 9'd1, "R2 first after reset", lfsr_state_o, 1);
        for (int i = 0; i < 30; i++) step(9'($urandom));

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule